// File: doc/BRIEF.md
# Multithreaded Windowed Register File

This block stores the integer registers of every hardware thread served by a single in-order pipeline that picks a new thread each cycle. All contexts share one storage array. Each thread owns a 64-entry aligned slot, and the physical address is the thread number followed by a 6-bit local index. Inside a slot, eight global registers are followed by three windows of sixteen entries. Each window holds its eight input registers and then its eight local registers. The output registers of a window are the same storage as the input registers of its neighbour, so no separate storage is kept for them.

The pipeline gives the block a thread number, that thread's current window pointer and two 5-bit source specifiers. The block returns both operands two clock edges later, and a new read can be issued on every cycle. One write port takes a thread, a window pointer, a destination specifier and a 32-bit word. No forwarding is done. The block also keeps a current window pointer and a 3-bit window-invalid mask for each thread. It steps the pointer on save and restore requests, and it flags window overflow or underflow when the target window is marked invalid.

Top module: `mt_win_regfile`

## Requirements
- R1: While reset is asserted and right after it: both read data outputs are zero, both window flags are low, and every thread's window pointer and invalid mask are zero.
- R2: Read data for specifiers presented with `issueTid`/`issueCwp` in one cycle appears on `rdData1`/`rdData2` after the second rising edge. A read may be issued every cycle, and the two ports read independently.
- R3: Register 0 reads as zero on both ports. A write to register 0 changes nothing.
- R4: Registers 1 to 7 are globals: one copy per thread, the same in every window. Threads never see each other's registers.
- R5: Within window w, registers 16-23 (locals) and 24-31 (ins) are private to that window. Register 8+k (outs) of window w is the same storage as register 24+k of window (w+2) mod 3.
- R6: A write takes effect at the rising edge where it is presented. A read issued in that same cycle to the same register returns the old value, and a read issued in a later cycle returns the new value.
- R7: With `winReq`=1, `winSave`=1 requests a save, which sets the pointer of `winTid` to (cwp+2) mod 3. `winSave`=0 requests a restore, which sets it to (cwp+1) mod 3. The new pointer shows on `winCwp` (the pointer of the thread on `winTid`) after that edge.
- R8: A save whose target window has its mask bit set (bit index = target window) leaves the pointer unchanged and raises `winOverflow` for exactly one cycle.
- R9: A restore whose target window has its mask bit set leaves the pointer unchanged and raises `winUnderflow` for exactly one cycle.
- R10: `wimWe` loads `wimData` into the mask of `wimTid` at the edge, and the new mask applies to requests from the next cycle onward. Window pointers and masks are kept separately for each thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueTid | input | 6 | Thread of the read being issued |
| issueCwp | input | 2 | Window pointer used for the read |
| rs1 | input | 5 | Source specifier, port 1 |
| rs2 | input | 5 | Source specifier, port 2 |
| rdData1 | output | 32 | Port 1 data, two edges after issue |
| rdData2 | output | 32 | Port 2 data, two edges after issue |
| wrEn | input | 1 | Write strobe |
| wrTid | input | 6 | Thread of the write |
| wrCwp | input | 2 | Window pointer used for the write |
| rd | input | 5 | Destination specifier |
| wrData | input | 32 | Write data |
| winReq | input | 1 | Save or restore request |
| winTid | input | 6 | Thread for the window request and for `winCwp` |
| winSave | input | 1 | 1 = save, 0 = restore |
| wimWe | input | 1 | Invalid-mask load strobe |
| wimTid | input | 6 | Thread whose mask is loaded |
| wimData | input | 3 | New invalid mask, bit i = window i |
| winCwp | output | 2 | Current window pointer of `winTid` |
| winOverflow | output | 1 | One-cycle pulse: save blocked |
| winUnderflow | output | 1 | One-cycle pulse: restore blocked |

## Verification
The hardest behaviour to reach is the case where the outs of one window and the ins of another share storage. It only shows when a value written through one window pointer is read back under a different register number through another pointer. The stimulus table is built around such pairs, and it also includes the top-numbered thread at the slot boundary. Blocked window moves need a thread's pointer walked to a chosen position and its mask loaded before the save or restore. The directed sequence does this on one thread while a second thread confirms that nothing leaks between threads. The read-old-on-collision case is produced by presenting a write and a read of the same register in the same cycle.

// File: rtl/mt_win_pkg.sv
package mt_win_pkg;
  parameter int TID_W   = 6;
  parameter int SLOT_W  = 6;
  parameter int DATA_W  = 32;
  parameter int REG_W   = 5;
  parameter int NWIN    = 3;
  parameter int CWP_W   = 2;
  parameter int NGLOBAL = 8;
  parameter int WIN_REGS = 16;
  localparam int THREADS = 1 << TID_W;
  localparam int ADDR_W  = TID_W + SLOT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] rdAddr1;
    logic [ADDR_W-1:0] rdAddr2;
    logic              rdZero1;
    logic              rdZero2;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
  } rfStrobe_t;

  // Architectural specifier plus window pointer -> index inside a thread slot.
  function automatic logic [SLOT_W-1:0] mapLocal(input logic [REG_W-1:0] r,
                                                 input logic [CWP_W-1:0] cwp);
    logic [CWP_W-1:0]  w;
    logic [SLOT_W-1:0] base;
    if (r[4:3] == 2'b01)
      w = (cwp == '0) ? CWP_W'(NWIN - 1) : cwp - 1'b1;
    else
      w = cwp;
    base = SLOT_W'(NGLOBAL) + SLOT_W'(w) * SLOT_W'(WIN_REGS);
    if (r[4:3] == 2'b00)
      return SLOT_W'(r);
    else if (r[4:3] == 2'b10)
      return base + SLOT_W'(NGLOBAL) + SLOT_W'(r[2:0]);
    else
      return base + SLOT_W'(r[2:0]);
  endfunction
endpackage

// File: rtl/mt_win_ctrl.sv
module mt_win_ctrl
  import mt_win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  issueTid,
  input  logic [CWP_W-1:0]  issueCwp,
  input  logic [REG_W-1:0]  rs1,
  input  logic [REG_W-1:0]  rs2,
  input  logic              wrEn,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [CWP_W-1:0]  wrCwp,
  input  logic [REG_W-1:0]  rd,
  input  logic              winReq,
  input  logic [TID_W-1:0]  winTid,
  input  logic              winSave,
  input  logic              wimWe,
  input  logic [TID_W-1:0]  wimTid,
  input  logic [NWIN-1:0]   wimData,
  output rfStrobe_t         strobe,
  output logic [CWP_W-1:0]  winCwp,
  output logic              winOverflow,
  output logic              winUnderflow
);
  logic [CWP_W-1:0] cwpTab [THREADS];
  logic [NWIN-1:0]  wimTab [THREADS];
  logic [CWP_W-1:0] curCwp, tgtCwp;
  logic             blocked;

  always_comb begin
    strobe.rdAddr1 = {issueTid, mapLocal(rs1, issueCwp)};
    strobe.rdAddr2 = {issueTid, mapLocal(rs2, issueCwp)};
    strobe.rdZero1 = (rs1 == '0);
    strobe.rdZero2 = (rs2 == '0);
    strobe.wrEn    = wrEn && (rd != '0);
    strobe.wrAddr  = {wrTid, mapLocal(rd, wrCwp)};
  end

  assign curCwp = cwpTab[winTid];
  assign winCwp = curCwp;

  always_comb begin
    if (winSave)
      tgtCwp = (curCwp == '0) ? CWP_W'(NWIN - 1) : curCwp - 1'b1;
    else
      tgtCwp = (curCwp == CWP_W'(NWIN - 1)) ? '0 : curCwp + 1'b1;
    blocked = wimTab[winTid][tgtCwp];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < THREADS; i++) begin
        cwpTab[i] <= '0;
        wimTab[i] <= '0;
      end
      winOverflow  <= 1'b0;
      winUnderflow <= 1'b0;
    end else begin
      if (winReq && !blocked) cwpTab[winTid] <= tgtCwp;
      if (wimWe) wimTab[wimTid] <= wimData;
      winOverflow  <= winReq && blocked && winSave;
      winUnderflow <= winReq && blocked && !winSave;
    end
  end
endmodule

// File: rtl/mt_win_data.sv
module mt_win_data
  import mt_win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] stage1A, stage1B;
  logic              zeroA, zeroB;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[strobe.wrAddr] <= wrData;
    stage1A <= mem[strobe.rdAddr1];
    stage1B <= mem[strobe.rdAddr2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroA   <= 1'b1;
      zeroB   <= 1'b1;
      rdData1 <= '0;
      rdData2 <= '0;
    end else begin
      zeroA   <= strobe.rdZero1;
      zeroB   <= strobe.rdZero2;
      rdData1 <= zeroA ? '0 : stage1A;
      rdData2 <= zeroB ? '0 : stage1B;
    end
  end
endmodule

// File: rtl/mt_win_regfile.sv
module mt_win_regfile
  import mt_win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  issueTid,
  input  logic [CWP_W-1:0]  issueCwp,
  input  logic [REG_W-1:0]  rs1,
  input  logic [REG_W-1:0]  rs2,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2,
  input  logic              wrEn,
  input  logic [TID_W-1:0]  wrTid,
  input  logic [CWP_W-1:0]  wrCwp,
  input  logic [REG_W-1:0]  rd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              winReq,
  input  logic [TID_W-1:0]  winTid,
  input  logic              winSave,
  input  logic              wimWe,
  input  logic [TID_W-1:0]  wimTid,
  input  logic [NWIN-1:0]   wimData,
  output logic [CWP_W-1:0]  winCwp,
  output logic              winOverflow,
  output logic              winUnderflow
);
  rfStrobe_t strobe;

  mt_win_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .issueTid(issueTid), .issueCwp(issueCwp),
    .rs1(rs1), .rs2(rs2), .wrEn(wrEn), .wrTid(wrTid), .wrCwp(wrCwp), .rd(rd),
    .winReq(winReq), .winTid(winTid), .winSave(winSave), .wimWe(wimWe),
    .wimTid(wimTid), .wimData(wimData), .strobe(strobe), .winCwp(winCwp),
    .winOverflow(winOverflow), .winUnderflow(winUnderflow)
  );

  mt_win_data data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData1(rdData1), .rdData2(rdData2)
  );
endmodule

// File: rtl/mt_win_regfile_chk.sv
module mt_win_regfile_chk
  import mt_win_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [REG_W-1:0]  rs1,
  input logic [REG_W-1:0]  rs2,
  input logic [DATA_W-1:0] rdData1,
  input logic [DATA_W-1:0] rdData2,
  input logic              winReq,
  input logic [TID_W-1:0]  winTid,
  input logic              winSave,
  input logic [CWP_W-1:0]  winCwp,
  input logic              winOverflow,
  input logic              winUnderflow
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 1'b1;
  end

  // R3
  zero_read1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3 && $past(rs1, 2) == '0) |-> rdData1 == '0);
  // R3
  zero_read2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3 && $past(rs2, 2) == '0) |-> rdData2 == '0);
  // R8
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen != 2'd0 && winOverflow) |-> $past(winReq && winSave));
  // R9
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen != 2'd0 && winUnderflow) |-> $past(winReq && !winSave));
  // R8
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen != 2'd0 && winTid == $past(winTid) && (winOverflow || winUnderflow))
      |-> winCwp == $past(winCwp));
  // R7
  cwp_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen != 2'd0 && $past(winReq) && winTid == $past(winTid) &&
     !winOverflow && !winUnderflow) |-> winCwp != $past(winCwp));
  // R7
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCwp != 2'd3);
endmodule

bind mt_win_regfile mt_win_regfile_chk chk_i (.*);

// File: tb/mt_win_regfile_tb_top.sv
`timescale 1ns/1ps
module mt_win_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  issueTid = '0, wrTid = '0, winTid = '0, wimTid = '0;
  logic [1:0]  issueCwp = '0, wrCwp = '0;
  logic [4:0]  rs1 = '0, rs2 = '0, rd = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0, winReq = 1'b0, winSave = 1'b0, wimWe = 1'b0;
  logic [2:0]  wimData = '0;
  logic [31:0] rdData1, rdData2;
  logic [1:0]  winCwp;
  logic        winOverflow, winUnderflow;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mt_win_regfile dut_i (.*);

  // write vectors: {tid, cwp, reg}; data = 32'hA000_0000 + index
  localparam logic [12:0] WR_VEC [8] = '{
    {6'd0, 2'd0, 5'd1}, {6'd0, 2'd0, 5'd8}, {6'd0, 2'd0, 5'd16}, {6'd0, 2'd0, 5'd24},
    {6'd0, 2'd1, 5'd9}, {6'd5, 2'd0, 5'd1}, {6'd63, 2'd2, 5'd31}, {6'd0, 2'd0, 5'd0}};
  // read vectors: {tid, cwp, reg, written index or 8'hFF for zero}
  localparam logic [20:0] RD_VEC [11] = '{
    {6'd0, 2'd2, 5'd1, 8'd0},   {6'd0, 2'd2, 5'd24, 8'd1},  {6'd0, 2'd0, 5'd16, 8'd2},
    {6'd0, 2'd0, 5'd24, 8'd3},  {6'd0, 2'd0, 5'd25, 8'd4},  {6'd5, 2'd1, 5'd1, 8'd5},
    {6'd0, 2'd1, 5'd1, 8'd0},   {6'd63, 2'd2, 5'd31, 8'd6}, {6'd63, 2'd0, 5'd15, 8'd6},
    {6'd0, 2'd0, 5'd0, 8'hFF},  {6'd0, 2'd1, 5'd8, 8'd3}};
  localparam string RD_REQ [11] = '{"R4", "R5", "R5", "R5", "R5", "R4", "R4",
                                    "R5", "R5", "R3", "R5"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] t, input logic [1:0] c, input logic [4:0] r,
                         input logic [31:0] d);
    wrEn = 1'b1; wrTid = t; wrCwp = c; rd = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic issue(input logic [5:0] t, input logic [1:0] c, input logic [4:0] a,
                       input logic [4:0] b);
    issueTid = t; issueCwp = c; rs1 = a; rs2 = b;
  endtask

  task automatic winOp(input logic [5:0] t, input logic s, output logic [1:0] cwp,
                       output logic ov, output logic un);
    winReq = 1'b1; winTid = t; winSave = s;
    @(negedge clk);
    winReq = 1'b0;
    cwp = winCwp; ov = winOverflow; un = winUnderflow;
  endtask

  task automatic setWim(input logic [5:0] t, input logic [2:0] m);
    wimWe = 1'b1; wimTid = t; wimData = m;
    @(negedge clk);
    wimWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] c;
    logic ov, un;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1", rdData1, 32'h0);
    chk("R1", {30'h0, winOverflow, winUnderflow}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", rdData2, 32'h0);
    winTid = 6'd17;
    #1 chk("R1", {30'h0, winCwp}, 32'h0);

    // table: writes, then reads (R2 latency, R3/R4/R5 mapping)
    for (int i = 0; i < 8; i++)
      doWrite(WR_VEC[i][12:7], WR_VEC[i][6:5], WR_VEC[i][4:0], 32'hA000_0000 + i);
    for (int i = 0; i < 11; i++) begin
      logic [31:0] exp;
      exp = (RD_VEC[i][7:0] == 8'hFF) ? 32'h0 : 32'hA000_0000 + RD_VEC[i][7:0];
      issue(RD_VEC[i][20:15], RD_VEC[i][14:13], RD_VEC[i][12:8], RD_VEC[i][12:8]);
      repeat (2) @(negedge clk);
      chk(RD_REQ[i], rdData1, exp);
      chk(RD_REQ[i], rdData2, exp);
    end

    // R2: back-to-back issue, independent ports
    issue(6'd0, 2'd0, 5'd16, 5'd24);
    @(negedge clk);
    issue(6'd63, 2'd2, 5'd31, 5'd0);
    @(negedge clk);
    chk("R2", rdData1, 32'hA000_0002);
    chk("R2", rdData2, 32'hA000_0003);
    @(negedge clk);
    chk("R2", rdData1, 32'hA000_0006);
    chk("R2", rdData2, 32'h0);

    // R6: same-cycle write and read of one register
    doWrite(6'd1, 2'd0, 5'd2, 32'h1111_1111);
    issue(6'd1, 2'd0, 5'd2, 5'd2);
    doWrite(6'd1, 2'd0, 5'd2, 32'h2222_2222);
    @(negedge clk);
    chk("R6", rdData1, 32'h1111_1111);
    @(negedge clk);
    chk("R6", rdData2, 32'h2222_2222);

    // R3: write to register 0 leaves it zero, and a global stays intact
    doWrite(6'd1, 2'd0, 5'd0, 32'hDEAD_BEEF);
    issue(6'd1, 2'd1, 5'd0, 5'd2);
    repeat (2) @(negedge clk);
    chk("R3", rdData1, 32'h0);
    chk("R3", rdData2, 32'h2222_2222);

    // R7: save / restore modulo 3 on thread 3
    winOp(6'd3, 1'b1, c, ov, un);
    chk("R7", {30'h0, c}, 32'd2);
    chk("R7", {30'h0, ov, un}, 32'h0);
    winOp(6'd3, 1'b0, c, ov, un);
    chk("R7", {30'h0, c}, 32'd0);
    winOp(6'd3, 1'b0, c, ov, un);
    chk("R7", {30'h0, c}, 32'd1);

    // R10 / R8: mask window 0, save from 1 is blocked
    setWim(6'd3, 3'b001);
    winOp(6'd3, 1'b1, c, ov, un);
    chk("R8", {30'h0, ov, un}, 32'h2);
    chk("R8", {30'h0, c}, 32'd1);
    @(negedge clk);
    chk("R8", {31'h0, winOverflow}, 32'h0);

    // R9: restore 1->2 fine, then 2->0 blocked
    winOp(6'd3, 1'b0, c, ov, un);
    chk("R9", {30'h0, c}, 32'd2);
    winOp(6'd3, 1'b0, c, ov, un);
    chk("R9", {30'h0, ov, un}, 32'h1);
    chk("R9", {30'h0, c}, 32'd2);
    @(negedge clk);
    chk("R9", {31'h0, winUnderflow}, 32'h0);

    // R10: another thread is unaffected by thread 3's mask
    winOp(6'd4, 1'b1, c, ov, un);
    chk("R10", {30'h0, ov, un}, 32'h0);
    chk("R10", {30'h0, c}, 32'd2);
    winTid = 6'd3;
    #1 chk("R10", {30'h0, winCwp}, 32'd2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule